// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

A 16-bit up-counter paired with a 16-bit holding register and an external trigger pin. The counter advances on one of three sources: a machine-cycle strobe, a falling edge seen on an event pin, or every clock cycle when it acts as a baud clock. The holding register plays two roles. In capture mode a trigger edge copies the running count into it. In auto-reload mode and baud mode the counter reloads from it when it overflows. In auto-reload mode a trigger edge also forces a reload.

Software reaches the block through a byte-wide register port. Five addresses cover the two count bytes, the two holding bytes and a control byte. The control byte carries the mode bits and two sticky flags: overflow and external trigger. A serial transmitter downstream uses the one-cycle baud pulse. An interrupt controller watches the two flags. The `clk` domain runs at half the oscillator rate. `mcTick` marks one clock per machine cycle. Both pins are assumed to be synchronous to `clk` already.

Top module: `tcr_timer`

## Requirements
- R1: After reset the count, the holding value and the control byte all read 0x00, and the overflow flag, the trigger flag and the baud pulse are all low.
- R2: A write stores the data byte at the given address, and a read returns it: 0 = count low, 1 = count high, 2 = holding low, 3 = holding high, 4 = control. Control bits are 0 run, 1 external source, 2 trigger enable, 3 capture mode, 4 baud mode, 5 reads 0, 6 overflow flag, 7 trigger flag. Addresses 5 to 7 read 0x00.
- R3: With run set and the internal source selected outside baud mode, the count rises by one on each clock that has `mcTick` high. With run clear it holds its value.
- R4: With the external source selected, the count rises by one when `mcTick` is high, the event pin sampled at the previous `mcTick` was 1 and the pin is now 0.
- R5: In auto-reload mode (bits 3 and 4 clear), an increment from 0xFFFF loads the holding value into the count and sets the overflow flag.
- R6: In capture mode (bit 3 set, bit 4 clear), an increment from 0xFFFF wraps the count to 0x0000 and sets the overflow flag.
- R7: In capture mode with trigger enable set, a trigger-pin falling edge (same sampling rule as R4) copies the current count into the holding register and sets the trigger flag.
- R8: In auto-reload mode with trigger enable set, a trigger-pin falling edge loads the holding value into the count and sets the trigger flag.
- R9: With trigger enable clear, a trigger edge leaves the holding value, the count and the trigger flag unchanged.
- R10: In baud mode (bit 4 set, which overrides bit 3), the internal source counts every clock. An overflow reloads the count from the holding register and raises `baudTick` for exactly the following cycle. An overflow in this mode does not set the overflow flag.
- R11: Writing the control byte writes both flags. A hardware set in the same cycle wins over a written 0.
- R12: A write to either count byte takes priority over any increment or reload in the same cycle. No overflow is reported for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at half the oscillator rate |
| rstN | input | 1 | Asynchronous reset, active low |
| mcTick | input | 1 | One-clock strobe per machine cycle |
| cntPin | input | 1 | External event input |
| trigPin | input | 1 | External capture/reload trigger |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register address |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr |
| ovfFlag | output | 1 | Sticky overflow flag |
| trigFlag | output | 1 | Sticky external-trigger flag |
| baudTick | output | 1 | One-cycle pulse per baud-mode overflow |

## Verification
The bench aims at the edges of the counting range. These are 0xFFFF in each mode, with its three different outcomes of reload, wrap, and reload with a pulse but no flag. A design that confused these would leave a wrong count in the register or set the overflow flag in baud mode. It also collides a flag-clearing write with an overflow, and a count write with an increment. A wrong priority shows up as a lost flag or a count one off from the value written. Trigger edges are sent with the enable both on and off. Pin levels that stay low or high across machine cycles are used to expose a design that counts levels rather than falling edges.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
  localparam int unsigned NBYTES = 2;

  localparam logic [2:0] ADDR_CNT_LO  = 3'd0;
  localparam logic [2:0] ADDR_CNT_HI  = 3'd1;
  localparam logic [2:0] ADDR_HOLD_LO = 3'd2;
  localparam logic [2:0] ADDR_HOLD_HI = 3'd3;
  localparam logic [2:0] ADDR_CTRL    = 3'd4;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_EXT   = 1;
  localparam int unsigned BIT_TEN   = 2;
  localparam int unsigned BIT_CAP   = 3;
  localparam int unsigned BIT_BAUD  = 4;
  localparam int unsigned BIT_OVF   = 6;
  localparam int unsigned BIT_TRIG  = 7;

  typedef struct packed {
    logic              incr;
    logic              reload;
    logic              capture;
    logic [NBYTES-1:0] wrCnt;
    logic [NBYTES-1:0] wrHold;
  } tcrStrobes_t;
endpackage

// File: rtl/tcr_dpath.sv
module tcr_dpath
  import tcr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tcrStrobes_t              stb,
  input  logic [BYTE_W-1:0]        wrData,
  output logic [NBYTES*BYTE_W-1:0] cnt,
  output logic [NBYTES*BYTE_W-1:0] hold,
  output logic                     atMax
);
  localparam int unsigned CNT_W = NBYTES * BYTE_W;

  logic [CNT_W-1:0] cntNext;
  logic             anyCntWr;

  assign anyCntWr = |stb.wrCnt;
  assign cntNext  = stb.reload ? hold : cnt + CNT_W'(1);
  assign atMax    = &cnt;

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [BYTE_W-1:0] cntLane;
    logic [BYTE_W-1:0] holdLane;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntLane <= '0;
      end else if (anyCntWr) begin
        if (stb.wrCnt[i]) cntLane <= wrData;
      end else if (stb.reload || stb.incr) begin
        cntLane <= cntNext[i*BYTE_W +: BYTE_W];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdLane <= '0;
      end else if (stb.capture) begin
        holdLane <= cnt[i*BYTE_W +: BYTE_W];
      end else if (stb.wrHold[i]) begin
        holdLane <= wrData;
      end
    end

    assign cnt[i*BYTE_W +: BYTE_W]  = cntLane;
    assign hold[i*BYTE_W +: BYTE_W] = holdLane;
  end

  // R3
  incr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.incr && !stb.reload && !(|stb.wrCnt)) |-> cnt == $past(cnt) + CNT_W'(1));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.reload && !(|stb.wrCnt)) |-> cnt == $past(hold));

  // R7
  capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.capture) |-> hold == $past(cnt));

  // R12
  cpu_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.wrCnt[0]) |-> cnt[BYTE_W-1:0] == $past(wrData));
endmodule

// File: rtl/tcr_ctrl.sv
module tcr_ctrl
  import tcr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcTick,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  input  logic              atMax,
  output tcrStrobes_t       stb,
  output logic [BYTE_W-1:0] ctrlByte,
  output logic              ovfFlag,
  output logic              trigFlag,
  output logic              baudTick
);
  logic run, extSrc, trigEn, capMode, baudMode;
  logic cntSample, trigSample;
  logic cntEdge, trigEdge, tickSrc, overflow, trigAct;
  logic capEff, reloadEff, wrCtrl;

  assign wrCtrl    = regWe && (regAddr == ADDR_CTRL);
  assign cntEdge   = mcTick && cntSample && !cntPin;
  assign trigEdge  = mcTick && trigSample && !trigPin;
  assign capEff    = !baudMode && capMode;
  assign reloadEff = !baudMode && !capMode;
  assign trigAct   = trigEdge && trigEn;

  always_comb begin
    if (extSrc)        tickSrc = cntEdge;
    else if (baudMode) tickSrc = 1'b1;
    else               tickSrc = mcTick;
  end

  always_comb begin
    stb.wrCnt[0]  = regWe && (regAddr == ADDR_CNT_LO);
    stb.wrCnt[1]  = regWe && (regAddr == ADDR_CNT_HI);
    stb.wrHold[0] = regWe && (regAddr == ADDR_HOLD_LO);
    stb.wrHold[1] = regWe && (regAddr == ADDR_HOLD_HI);
    stb.incr      = run && tickSrc && !(|stb.wrCnt);
    stb.capture   = trigAct && capEff;
    stb.reload    = !(|stb.wrCnt) &&
                    ((stb.incr && atMax && !capEff) || (trigAct && reloadEff));
  end

  assign overflow = stb.incr && atMax;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntSample  <= 1'b0;
      trigSample <= 1'b0;
    end else if (mcTick) begin
      cntSample  <= cntPin;
      trigSample <= trigPin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run      <= 1'b0;
      extSrc   <= 1'b0;
      trigEn   <= 1'b0;
      capMode  <= 1'b0;
      baudMode <= 1'b0;
      ovfFlag  <= 1'b0;
      trigFlag <= 1'b0;
      baudTick <= 1'b0;
    end else begin
      if (wrCtrl) begin
        run      <= regWdata[BIT_RUN];
        extSrc   <= regWdata[BIT_EXT];
        trigEn   <= regWdata[BIT_TEN];
        capMode  <= regWdata[BIT_CAP];
        baudMode <= regWdata[BIT_BAUD];
      end
      ovfFlag  <= (wrCtrl ? regWdata[BIT_OVF] : ovfFlag) | (overflow && !baudMode);
      trigFlag <= (wrCtrl ? regWdata[BIT_TRIG] : trigFlag) | trigAct;
      baudTick <= overflow && baudMode;
    end
  end

  always_comb begin
    ctrlByte           = '0;
    ctrlByte[BIT_RUN]  = run;
    ctrlByte[BIT_EXT]  = extSrc;
    ctrlByte[BIT_TEN]  = trigEn;
    ctrlByte[BIT_CAP]  = capMode;
    ctrlByte[BIT_BAUD] = baudMode;
    ctrlByte[BIT_OVF]  = ovfFlag;
    ctrlByte[BIT_TRIG] = trigFlag;
  end

  // R10
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag) |-> $past(wrCtrl) || $past(atMax && !baudMode));

  // R9
  trig_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(trigFlag) |-> $past(wrCtrl) || $past(trigEn));

  // R10
  baud_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> $past(baudMode && atMax));

  // R12
  no_ovf_on_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|stb.wrCnt) |-> !stb.incr && !stb.reload);
endmodule

// File: rtl/tcr_timer.sv
module tcr_timer
  import tcr_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcTick,
  input  logic              cntPin,
  input  logic              trigPin,
  input  logic              regWe,
  input  logic [2:0]        regAddr,
  input  logic [BYTE_W-1:0] regWdata,
  output logic [BYTE_W-1:0] regRdata,
  output logic              ovfFlag,
  output logic              trigFlag,
  output logic              baudTick
);
  localparam int unsigned CNT_W = NBYTES * BYTE_W;

  tcrStrobes_t       stb;
  logic [CNT_W-1:0]  cnt, hold;
  logic              atMax;
  logic [BYTE_W-1:0] ctrlByte;

  tcr_ctrl #(.BYTE_W(BYTE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .mcTick(mcTick), .cntPin(cntPin), .trigPin(trigPin),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .atMax(atMax),
    .stb(stb), .ctrlByte(ctrlByte), .ovfFlag(ovfFlag), .trigFlag(trigFlag),
    .baudTick(baudTick)
  );

  tcr_dpath #(.BYTE_W(BYTE_W)) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWdata),
    .cnt(cnt), .hold(hold), .atMax(atMax)
  );

  always_comb begin
    case (regAddr)
      ADDR_CNT_LO:  regRdata = cnt[BYTE_W-1:0];
      ADDR_CNT_HI:  regRdata = cnt[CNT_W-1:BYTE_W];
      ADDR_HOLD_LO: regRdata = hold[BYTE_W-1:0];
      ADDR_HOLD_HI: regRdata = hold[CNT_W-1:BYTE_W];
      ADDR_CTRL:    regRdata = ctrlByte;
      default:      regRdata = '0;
    endcase
  end
endmodule

// File: tb/tcr_timer_tb_top.sv
module tcr_timer_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mcTick = 1'b0, cntPin = 1'b0, trigPin = 1'b0, regWe = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWdata = 8'd0;
  logic [7:0] regRdata;
  logic ovfFlag, trigFlag, baudTick;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tcr_timer dut_i (
    .clk(clk), .rstN(rstN), .mcTick(mcTick), .cntPin(cntPin), .trigPin(trigPin),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .ovfFlag(ovfFlag), .trigFlag(trigFlag), .baudTick(baudTick)
  );

  localparam logic [7:0] RUN = 8'h01, EXT = 8'h02, TEN = 8'h04, CAP = 8'h08, BAUD = 8'h10;

  // behavioural reference state
  int mCnt = 0, mHold = 0;
  bit mRun, mExt, mTen, mCap, mBaud, mOvf, mTrig, mTick, mCs, mTs;

  function automatic int expRead(input int a);
    case (a)
      0: return mCnt & 255;
      1: return (mCnt >> 8) & 255;
      2: return mHold & 255;
      3: return (mHold >> 8) & 255;
      4: return (int'(mTrig) << 7) | (int'(mOvf) << 6) | (int'(mBaud) << 4) |
                (int'(mCap) << 3) | (int'(mTen) << 2) | (int'(mExt) << 1) | int'(mRun);
      default: return 0;
    endcase
  endfunction

  task automatic modelStep(input bit we, input int a, input int d, input bit mc, cp, tp);
    bit cntWr, cEdge, tEdge, src, inc, ovf, tAct, capE, relE;
    int nCnt, nHold;
    cntWr = we && (a == 0 || a == 1);
    cEdge = mc && mCs && !cp;
    tEdge = mc && mTs && !tp;
    src   = mExt ? cEdge : (mBaud ? 1'b1 : mc);
    inc   = mRun && src && !cntWr;
    ovf   = inc && (mCnt == 65535);
    tAct  = tEdge && mTen;
    capE  = !mBaud && mCap;
    relE  = !mBaud && !mCap;
    nCnt = mCnt; nHold = mHold;
    if (cntWr) begin
      if (a == 0) nCnt = (mCnt & 16'hFF00) | d;
      else        nCnt = (mCnt & 16'h00FF) | (d << 8);
    end else if ((ovf && !capE) || (tAct && relE)) nCnt = mHold;
    else if (inc) nCnt = (mCnt + 1) % 65536;
    if (tAct && capE) nHold = mCnt;
    else if (we && a == 2) nHold = (mHold & 16'hFF00) | d;
    else if (we && a == 3) nHold = (mHold & 16'h00FF) | (d << 8);
    mOvf  = ((we && a == 4) ? d[6] : mOvf) | (ovf && !mBaud);
    mTrig = ((we && a == 4) ? d[7] : mTrig) | tAct;
    mTick = ovf && mBaud;
    if (we && a == 4) begin
      mRun = d[0]; mExt = d[1]; mTen = d[2]; mCap = d[3]; mBaud = d[4];
    end
    if (mc) begin mCs = cp; mTs = tp; end
    mCnt = nCnt; mHold = nHold;
  endtask

  task automatic compare(input string tag);
    int e;
    e = expRead(int'(regAddr));
    vecs++;
    if (int'(regRdata) != e || ovfFlag != mOvf || trigFlag != mTrig || baudTick != mTick) begin
      errs++;
      $display("FAIL %s addr=%0d rdata=%02h/%02h ovf=%0b/%0b trig=%0b/%0b baud=%0b/%0b (actual/expected)",
               tag, regAddr, regRdata, e, ovfFlag, mOvf, trigFlag, mTrig, baudTick, mTick);
    end
  endtask

  task automatic step(input bit we, input int a, input int d, input bit mc, cp, tp, input string tag);
    regWe = we; regAddr = 3'(a); regWdata = 8'(d); mcTick = mc; cntPin = cp; trigPin = tp;
    @(posedge clk);
    @(negedge clk);
    modelStep(we, a, d, mc, cp, tp);
    compare(tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    step(1, a, d, 0, cntPin, trigPin, tag);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    for (int a = 0; a < 5; a++) step(0, a, 0, 0, 0, 0, "R1");

    // R2: register access
    wr(0, 8'hAB, "R2"); wr(1, 8'hCD, "R2"); wr(2, 8'h12, "R2"); wr(3, 8'h34, "R2");
    wr(4, CAP | TEN, "R2");
    for (int a = 0; a < 8; a++) step(0, a, 0, 0, 0, 0, "R2");
    wr(4, 0, "R2");

    // R3: internal tick and run gating
    wr(0, 0, "R3"); wr(1, 0, "R3"); wr(4, RUN, "R3");
    for (int i = 0; i < 30; i++) step(0, i % 2, 0, (i % 3) == 0, 0, 0, "R3");
    wr(4, 0, "R3");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, "R3");

    // R4: external falling edges
    wr(4, RUN | EXT, "R4");
    for (int i = 0; i < 40; i++) step(0, 0, 0, (i % 2) == 0, ((i / 4) % 2) == 1, 0, "R4");
    for (int i = 0; i < 12; i++) step(0, 0, 0, 1, (i % 2) == 1, 0, "R4");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 0, 0, "R4");

    // R5: auto-reload overflow
    wr(4, 0, "R5"); wr(0, 8'hF0, "R5"); wr(1, 8'hFF, "R5");
    wr(2, 8'h34, "R5"); wr(3, 8'h12, "R5"); wr(4, RUN, "R5");
    for (int i = 0; i < 25; i++) step(0, (i % 2) ? 4 : 0, 0, 1, 0, 0, "R5");

    // R11: flag clear and set-wins collision
    wr(4, RUN, "R11");
    step(0, 4, 0, 0, 0, 0, "R11");
    wr(4, 0, "R11"); wr(0, 8'hFF, "R11"); wr(1, 8'hFF, "R11"); wr(4, RUN, "R11");
    step(1, 4, RUN, 1, 0, 0, "R11");
    step(0, 4, 0, 0, 0, 0, "R11");

    // R6: capture-mode wrap
    wr(4, 0, "R6"); wr(0, 8'hF8, "R6"); wr(1, 8'hFF, "R6"); wr(4, RUN | CAP, "R6");
    for (int i = 0; i < 15; i++) step(0, (i % 3 == 2) ? 4 : i % 2, 0, 1, 0, 0, "R6");

    // R7: capture on trigger edge
    wr(4, RUN | CAP | TEN, "R7"); wr(0, 0, "R7"); wr(1, 0, "R7");
    for (int i = 0; i < 24; i++) step(0, 2 + (i % 3), 0, 1, 0, ((i / 3) % 2) == 1, "R7");

    // R9: trigger ignored without enable
    wr(4, RUN | CAP, "R9"); wr(2, 8'h55, "R9"); wr(3, 8'h66, "R9");
    for (int i = 0; i < 20; i++) step(0, (i % 2) ? 4 : 2, 0, 1, 0, ((i / 2) % 2) == 1, "R9");
    wr(4, RUN, "R9");
    for (int i = 0; i < 12; i++) step(0, 1, 0, 1, 0, ((i / 2) % 2) == 1, "R9");

    // R8: reload on trigger edge
    wr(4, RUN | TEN, "R8"); wr(2, 8'h00, "R8"); wr(3, 8'h80, "R8");
    for (int i = 0; i < 24; i++) step(0, (i % 2) ? 4 : 1, 0, 1, 0, ((i / 5) % 2) == 1, "R8");

    // R10: baud mode
    wr(4, 0, "R10"); wr(2, 8'hFC, "R10"); wr(3, 8'hFF, "R10");
    wr(0, 8'hFC, "R10"); wr(1, 8'hFF, "R10"); wr(4, RUN | BAUD | CAP, "R10");
    for (int i = 0; i < 20; i++) step(0, (i % 2) ? 4 : 0, 0, i % 2, 0, 0, "R10");

    // R12: count write beats increment
    wr(4, 0, "R12"); wr(0, 8'hFF, "R12"); wr(1, 8'hFF, "R12"); wr(4, RUN, "R12");
    step(1, 0, 8'h10, 1, 0, 0, "R12");
    step(0, 0, 0, 0, 0, 0, "R12");
    step(0, 1, 0, 0, 0, 0, "R12");
    step(0, 4, 0, 0, 0, 0, "R12");

    // mixed random traffic (R2 through R12)
    for (int i = 0; i < 4000; i++) begin
      int a;
      bit we;
      we = ($urandom % 8) == 0;
      a  = $urandom % 6;
      step(we, a, $urandom % 256, ($urandom % 2) == 1, ($urandom % 2) == 1,
           ($urandom % 4) == 0, "R5-mix");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule